// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Bank

The block holds four 8-bit interval timers behind a small byte-addressed register bus. Each timer has a mode register, a reload (base) register and a counter that software can only read. A timer whose count enable is set and whose clock select picks the tick input counts down once per `tick` pulse. When it finishes a period it emits a one-clock pulse on its own bit of `uflow` and restarts from its base register. A period is therefore as many ticks as the base value. A base of zero leaves the timer idle.

Any timer other than timer 0 can be set to follow the timer below it. The two timers then act as one 16-bit counter. Its reload value has the lower timer's base as the low byte and the upper timer's base as the high byte. The lower timer reports the underflow. While a timer is stopped, a base write also presets its counter, and a counter read returns the base value. While a timer runs, a base write takes effect only at the next reload. Mode, base and counter registers can be read as single bytes, as aligned pairs or as the whole bank. Packed reads place the lower-numbered timer in the more significant byte, and base writes use the same packing. Any illegal access sets a sticky error flag, and the access changes nothing else.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset every mode, base and counter register reads zero, `err_flag` is 0 and `uflow` is 0.
- R2: A mode byte uses bit 7 = count enable, bit 6 = load, bits 1:0 = clock select (00 tick input, 11 follow the next-lower timer). A mode write is rejected with an error and leaves the mode unchanged in four cases: any of bits 5:2 is set, bits 7 and 6 are both set, the clock select is 01 or 10, or the access is not a single byte.
- R3: While a timer's count enable is clear, a base write also loads its counter, and a counter read returns the base register value.
- R4: While a timer counts, a base write leaves the running counter unchanged. The new base is used from the next reload on.
- R5: Enabling a timer with tick clock select loads the counter from base. Each `tick` then decrements it. The tick that ends a period reloads the counter and raises that timer's `uflow` bit for exactly one clock, in the cycle after the tick, so underflows recur every base-value ticks. A base of zero gives no counting and no underflow.
- R6: With timer i+1 set to follow and enabled, enabling timer i counts the pair as one 16-bit value {base[i+1], base[i]}. The borrow runs from the low byte into the high byte. Only `uflow[i]` pulses, and a following timer never pulses its own bit.
- R7: Selecting clock select 11 on timer 0 is an error. Enabling timer i with tick select while timer i+1 is set to follow but not enabled is an error. Both writes are rejected.
- R8: `bus_size` codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Mode registers sit at 0x00+i, base registers at 0x10+i and counters at 0x20+i. A 2-byte access is legal only at timer 0 or 2, and a 4-byte access only at timer 0. Data is packed with the lowest timer in the most significant used byte. Any other size or alignment is an error, and such a read returns 0.
- R9: Any write to the counter range, and any access to an unmapped address, is an error and changes no state.
- R10: The error flag reads as bit 0 at 0x30 with 1-byte access. It stays set until a 1-byte write to 0x30 with bit 0 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable for timers on tick select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data, packed by size |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| err_flag | output | 1 | Sticky illegal-access flag |
| uflow | output | 4 | Per-timer underflow pulse |

## Verification
A corrupted counter appears at the counter read one cycle after the read strobe. It also shifts the next `uflow` pulse by the size of the error, within one reload period. A broken borrow or reload path in a cascaded pair changes the period by whole multiples of 256 ticks, which the mid-period packed counter reads show at once. A rejected access that still changed state shows on the next read of the targeted register. A flag that fails to latch or to clear shows on the next read of the error byte.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  typedef struct packed {
    logic       cne;
    logic       ld;
    logic [3:0] rsv;
    logic [1:0] csel;
  } tmr_mode_t;

  localparam logic [1:0] CSEL_TICK  = 2'b00;
  localparam logic [1:0] CSEL_CHAIN = 2'b11;

  localparam int REG_MODE = 0;
  localparam int REG_BASE = 1;
  localparam int REG_CNT  = 2;
  localparam int REG_ERR  = 3;
endpackage

// File: rtl/ctb_slice.sv
module ctb_slice
  import ctb_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  tmr_mode_t     mode_wval,
  input  logic          base_we,
  input  logic [TW-1:0] base_wval,
  input  logic          cnt_load,
  input  logic          rld,
  input  logic          dec,
  output tmr_mode_t     mode_q,
  output logic [TW-1:0] base_q,
  output logic [TW-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (mode_we) mode_q <= mode_wval;
      if (base_we) base_q <= base_wval;
      if (base_we && !mode_q.cne) cnt_q <= base_wval;
      else if (cnt_load)          cnt_q <= base_q;
      else if (rld)               cnt_q <= base_q;
      else if (dec)               cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ctb_chain.sv
module ctb_chain #(
  parameter int N_TMR = 4,
  parameter int TW    = 8
) (
  input  logic                      tick,
  input  logic [N_TMR-1:0]          head,
  input  logic [N_TMR-1:0]          pair,
  input  logic [N_TMR-1:0][TW-1:0]  cnt_q,
  output logic [N_TMR-1:0]          dec,
  output logic [N_TMR-1:0]          rld,
  output logic [N_TMR-1:0]          uflow_evt
);
  logic [N_TMR-1:0]         live, last;
  logic [N_TMR-1:0][TW-1:0] hi_eff;

  for (genvar g = 0; g < N_TMR; g++) begin : g_lane
    if (g < N_TMR-1) begin : g_hi
      assign hi_eff[g] = pair[g] ? cnt_q[g+1] : '0;
    end else begin : g_nohi
      assign hi_eff[g] = pair[g] ? cnt_q[g] : '0;
    end
    assign live[g]      = tick && head[g] && !(cnt_q[g] == '0 && hi_eff[g] == '0);
    assign last[g]      = (cnt_q[g] == TW'(1)) && (hi_eff[g] == '0);
    assign uflow_evt[g] = live[g] && last[g];
    if (g > 0) begin : g_up
      assign rld[g] = (live[g] && last[g]) ||
                      (pair[g-1] && live[g-1] && last[g-1]);
      assign dec[g] = (live[g] && !last[g]) ||
                      (pair[g-1] && live[g-1] && !last[g-1] && cnt_q[g-1] == '0);
    end else begin : g_base
      assign rld[g] = live[g] && last[g];
      assign dec[g] = live[g] && !last[g];
    end
  end
endmodule

// File: rtl/ctb_bus_decode.sv
module ctb_bus_decode
  import ctb_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int TW     = 8,
  parameter int ADDR_W = 8
) (
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [1:0]                bus_size,
  input  logic [4*TW-1:0]           bus_wdata,
  input  tmr_mode_t [N_TMR-1:0]     mode_q,
  input  logic [N_TMR-1:0][TW-1:0]  base_q,
  input  logic [N_TMR-1:0][TW-1:0]  cnt_q,
  input  logic                      err_q,
  output logic [N_TMR-1:0]          mode_we,
  output tmr_mode_t                 mode_wval,
  output logic [N_TMR-1:0]          base_we,
  output logic [N_TMR-1:0][TW-1:0]  base_wval,
  output logic [N_TMR-1:0]          cnt_load,
  output logic                      acc_err,
  output logic                      err_clr,
  output logic [4*TW-1:0]           rd_val
);
  localparam int DW = 4*TW;

  logic [N_TMR-1:0] up_block, own_en, own_ld, pair_load;
  logic             wr_err, rd_err, span_ok, hit, bad_mode;
  int               lane_i, region_i, nb, k;
  tmr_mode_t        wv;
  logic [TW-1:0]    lane_val;

  for (genvar g = 0; g < N_TMR; g++) begin : g_nb
    if (g < N_TMR-1) begin : g_up
      assign up_block[g]    = (mode_q[g+1].csel == CSEL_CHAIN) && !mode_q[g+1].cne;
      assign pair_load[g+1] = own_en[g] && (mode_q[g+1].csel == CSEL_CHAIN) && mode_q[g+1].cne;
    end else begin : g_top
      assign up_block[g] = 1'b0;
    end
  end
  assign pair_load[0] = 1'b0;
  assign cnt_load     = own_en | own_ld | pair_load;
  assign mode_wval    = wv;
  assign acc_err      = wr_err | rd_err;

  always_comb begin
    lane_i   = int'(bus_addr[3:0]);
    region_i = int'(bus_addr[ADDR_W-1:4]);
    case (bus_size)
      2'd0:    nb = 1;
      2'd1:    nb = 2;
      2'd2:    nb = 4;
      default: nb = 0;
    endcase
    span_ok = 1'b0;
    if (nb == 1)      span_ok = lane_i < N_TMR;
    else if (nb == 2) span_ok = (lane_i % 2 == 0) && (lane_i + 1 < N_TMR);
    else if (nb == 4) span_ok = (lane_i % 4 == 0) && (lane_i + 3 < N_TMR);
    wv       = tmr_mode_t'(bus_wdata[7:0]);
    bad_mode = (nb != 1) || (wv.rsv != '0) || (wv.cne && wv.ld) ||
               (wv.csel == 2'b01) || (wv.csel == 2'b10);
    mode_we   = '0;
    base_we   = '0;
    base_wval = '0;
    own_en    = '0;
    own_ld    = '0;
    wr_err    = 1'b0;
    rd_err    = 1'b0;
    err_clr   = 1'b0;
    rd_val    = '0;
    hit       = 1'b0;
    k         = 0;
    lane_val  = '0;

    if (bus_wr) begin
      case (region_i)
        REG_MODE: begin
          for (int i = 0; i < N_TMR; i++) begin
            if (lane_i == i) begin
              hit = 1'b1;
              if (bad_mode || (i == 0 && wv.csel == CSEL_CHAIN) ||
                  (wv.cne && wv.csel == CSEL_TICK && up_block[i])) begin
                wr_err = 1'b1;
              end else begin
                mode_we[i] = 1'b1;
                own_en[i]  = wv.cne && (wv.csel == CSEL_TICK);
                own_ld[i]  = wv.ld;
              end
            end
          end
          if (!hit) wr_err = 1'b1;
        end
        REG_BASE: begin
          if (span_ok) begin
            for (int i = 0; i < N_TMR; i++) begin
              if (i >= lane_i && i < lane_i + nb) begin
                k            = i - lane_i;
                base_we[i]   = 1'b1;
                base_wval[i] = bus_wdata[(nb-1-k)*TW +: TW];
              end
            end
          end else begin
            wr_err = 1'b1;
          end
        end
        REG_ERR: begin
          if (nb == 1 && lane_i == 0) err_clr = bus_wdata[0];
          else                        wr_err  = 1'b1;
        end
        default: wr_err = 1'b1;
      endcase
    end

    if (bus_rd) begin
      case (region_i)
        REG_MODE, REG_BASE, REG_CNT: begin
          if (span_ok) begin
            for (int i = 0; i < N_TMR; i++) begin
              if (i >= lane_i && i < lane_i + nb) begin
                k = i - lane_i;
                if (region_i == REG_MODE)      lane_val = TW'(mode_q[i]);
                else if (region_i == REG_BASE) lane_val = base_q[i];
                else                           lane_val = mode_q[i].cne ? cnt_q[i] : base_q[i];
                rd_val[(nb-1-k)*TW +: TW] = lane_val;
              end
            end
          end else begin
            rd_err = 1'b1;
          end
        end
        REG_ERR: begin
          if (nb == 1 && lane_i == 0) rd_val = DW'(err_q);
          else                        rd_err = 1'b1;
        end
        default: rd_err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank
  import ctb_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int TW     = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [4*TW-1:0]   bus_wdata,
  output logic [4*TW-1:0]   bus_rdata,
  output logic              err_flag,
  output logic [N_TMR-1:0]  uflow
);
  tmr_mode_t [N_TMR-1:0]     mode_q;
  logic [N_TMR-1:0][TW-1:0]  base_q, cnt_q, base_wval;
  logic [N_TMR-1:0]          mode_we, base_we, cnt_load, dec, rld, uflow_evt;
  logic [N_TMR-1:0]          head, pair;
  tmr_mode_t                 mode_wval;
  logic                      acc_err, err_clr;
  logic [4*TW-1:0]           rd_val;

  ctb_bus_decode #(.N_TMR(N_TMR), .TW(TW), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .mode_q(mode_q), .base_q(base_q), .cnt_q(cnt_q),
    .err_q(err_flag), .mode_we(mode_we), .mode_wval(mode_wval),
    .base_we(base_we), .base_wval(base_wval), .cnt_load(cnt_load),
    .acc_err(acc_err), .err_clr(err_clr), .rd_val(rd_val)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign head[g] = mode_q[g].cne && (mode_q[g].csel == CSEL_TICK);
    if (g < N_TMR-1) begin : g_pair
      assign pair[g] = head[g] && mode_q[g+1].cne && (mode_q[g+1].csel == CSEL_CHAIN);
    end else begin : g_nopair
      assign pair[g] = 1'b0;
    end
    ctb_slice #(.TW(TW)) u_slice (
      .clk(clk), .rst(rst), .mode_we(mode_we[g]), .mode_wval(mode_wval),
      .base_we(base_we[g]), .base_wval(base_wval[g]), .cnt_load(cnt_load[g]),
      .rld(rld[g]), .dec(dec[g]), .mode_q(mode_q[g]), .base_q(base_q[g]),
      .cnt_q(cnt_q[g])
    );
  end

  ctb_chain #(.N_TMR(N_TMR), .TW(TW)) u_chain (
    .tick(tick), .head(head), .pair(pair), .cnt_q(cnt_q),
    .dec(dec), .rld(rld), .uflow_evt(uflow_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      err_flag  <= 1'b0;
      uflow     <= '0;
    end else begin
      uflow <= uflow_evt;
      if (bus_rd)       bus_rdata <= rd_val;
      if (acc_err)      err_flag  <= 1'b1;
      else if (err_clr) err_flag  <= 1'b0;
    end
  end
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker
  import ctb_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int TW     = 8,
  parameter int ADDR_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      tick,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [1:0]                bus_size,
  input logic                      bus_wd0,
  input tmr_mode_t [N_TMR-1:0]     mode_q,
  input logic [N_TMR-1:0][TW-1:0]  cnt_q,
  input logic [N_TMR-1:0]          uflow,
  input logic                      err_flag
);
  AST_UFLOW_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (uflow != '0) |-> $past(tick)); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !bus_wr) |=> $stable(cnt_q)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> (err_flag || $past(bus_wr && bus_addr == ADDR_W'(8'h30) && bus_size == 2'd0 && bus_wd0))); // R10

  AST_CNT_WR_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(2)) |=> err_flag); // R9

  AST_T0_NO_CHAIN: assert property (@(posedge clk) disable iff (rst)
    mode_q[0].csel != CSEL_CHAIN); // R7

  for (genvar g = 0; g < N_TMR; g++) begin : g_chk
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g].rsv == '0) && !(mode_q[g].cne && mode_q[g].ld)); // R2
    if (g > 0) begin : g_up
      AST_UPPER_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_q[g].csel == CSEL_CHAIN) |=> !uflow[g]); // R6
    end
  end
endmodule

bind cascade_timer_bank ctb_checker #(.N_TMR(N_TMR), .TW(TW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wd0(bus_wdata[0]), .mode_q(mode_q), .cnt_q(cnt_q),
  .uflow(uflow), .err_flag(err_flag)
);

// File: tb/cascade_timer_bank_tb.sv
`timescale 1ns/1ps
module cascade_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        err_flag;
  logic [3:0]  uflow;

  int tests = 0;
  int fails = 0;
  int uf_cnt [4];
  int wide_cnt = 0;
  logic [31:0] rv;

  cascade_timer_bank u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .err_flag(err_flag), .uflow(uflow)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = s;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] a, input logic [1:0] s,
                           input logic [31:0] exp);
    logic [31:0] d;
    rd(a, s, d);
    check(tag, d, exp);
  endtask

  task automatic clear_err();
    wr(8'h30, 2'd0, 32'h1);
  endtask

  task automatic run_ticks(input int n);
    for (int b = 0; b < 4; b++) uf_cnt[b] = 0;
    wide_cnt = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (uflow != 4'h0) wide_cnt++;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      for (int b = 0; b < 4; b++) if (uflow[b]) uf_cnt[b]++;
    end
  endtask

  task automatic t_reset();
    check("R1 uflow after reset", {28'h0, uflow}, 32'h0);
    check("R1 err after reset", {31'h0, err_flag}, 32'h0);
    expect_rd("R1 modes zero", 8'h00, 2'd2, 32'h0);
    expect_rd("R1 bases zero", 8'h10, 2'd2, 32'h0);
    expect_rd("R1 counters zero", 8'h20, 2'd2, 32'h0);
    expect_rd("R1 err byte zero", 8'h30, 2'd0, 32'h0);
  endtask

  task automatic t_stopped_base();
    wr(8'h11, 2'd0, 32'h5A);
    expect_rd("R3 stopped counter follows base", 8'h21, 2'd0, 32'h5A);
  endtask

  task automatic t_packing();
    wr(8'h10, 2'd2, 32'h11223344);
    expect_rd("R8 byte read t0", 8'h10, 2'd0, 32'h11);
    expect_rd("R8 byte read t3", 8'h13, 2'd0, 32'h44);
    expect_rd("R8 pair read t2", 8'h12, 2'd1, 32'h3344);
    expect_rd("R8 quad counter read", 8'h20, 2'd2, 32'h11223344);
    wr(8'h10, 2'd1, 32'hA0B0);
    expect_rd("R8 pair write order", 8'h10, 2'd2, 32'hA0B03344);
  endtask

  task automatic t_bad_sizes();
    expect_rd("R8 misaligned pair read data", 8'h11, 2'd1, 32'h0);
    check("R8 misaligned pair read err", {31'h0, err_flag}, 32'h1);
    expect_rd("R10 legal read after err", 8'h10, 2'd0, 32'hA0);
    expect_rd("R10 err stays set", 8'h30, 2'd0, 32'h1);
    clear_err();
    expect_rd("R10 err cleared", 8'h30, 2'd0, 32'h0);
    wr(8'h12, 2'd2, 32'hDEADBEEF);
    check("R8 quad write at t2 err", {31'h0, err_flag}, 32'h1);
    expect_rd("R8 rejected write no change", 8'h10, 2'd2, 32'hA0B03344);
    wr(8'h30, 2'd0, 32'h0);
    expect_rd("R10 write zero keeps err", 8'h30, 2'd0, 32'h1);
    clear_err();
  endtask

  task automatic t_count();
    wr(8'h10, 2'd0, 32'h3);
    wr(8'h00, 2'd0, 32'h80);
    expect_rd("R5 counter loaded at enable", 8'h20, 2'd0, 32'h3);
    run_ticks(2);
    expect_rd("R5 counter after two ticks", 8'h20, 2'd0, 32'h1);
    check("R5 no early underflow", uf_cnt[0], 0);
    run_ticks(1);
    check("R5 underflow on third tick", uf_cnt[0], 1);
    expect_rd("R5 reload after underflow", 8'h20, 2'd0, 32'h3);
    run_ticks(9);
    check("R5 underflow every base ticks", uf_cnt[0], 3);
    check("R5 single clock pulse", wide_cnt, 0);
  endtask

  task automatic t_running_base();
    wr(8'h10, 2'd0, 32'h5);
    expect_rd("R4 running counter untouched", 8'h20, 2'd0, 32'h3);
    run_ticks(3);
    check("R4 old period completes", uf_cnt[0], 1);
    expect_rd("R4 new base at reload", 8'h20, 2'd0, 32'h5);
    run_ticks(5);
    check("R4 new period used", uf_cnt[0], 1);
    wr(8'h00, 2'd0, 32'h00);
    wr(8'h10, 2'd0, 32'h42);
    expect_rd("R3 stopped counter reads base", 8'h20, 2'd0, 32'h42);
  endtask

  task automatic t_base_zero();
    wr(8'h11, 2'd0, 32'h0);
    wr(8'h01, 2'd0, 32'h80);
    run_ticks(5);
    check("R5 zero base no underflow", uf_cnt[1], 0);
    expect_rd("R5 zero base counter idle", 8'h21, 2'd0, 32'h0);
    wr(8'h01, 2'd0, 32'h00);
  endtask

  task automatic t_cascade();
    wr(8'h12, 2'd1, 32'h0201);
    wr(8'h03, 2'd0, 32'h83);
    wr(8'h02, 2'd0, 32'h80);
    check("R6 legal enable order no err", {31'h0, err_flag}, 32'h0);
    expect_rd("R6 pair loaded", 8'h22, 2'd1, 32'h0201);
    run_ticks(3);
    expect_rd("R6 borrow into high byte", 8'h22, 2'd1, 32'hFF00);
    run_ticks(254);
    check("R6 no early underflow", uf_cnt[2], 0);
    expect_rd("R6 pair near end", 8'h22, 2'd1, 32'h0100);
    run_ticks(1);
    check("R6 lower reports underflow", uf_cnt[2], 1);
    check("R6 upper stays silent", uf_cnt[3], 0);
    expect_rd("R6 pair reloaded", 8'h22, 2'd1, 32'h0201);
    wr(8'h02, 2'd0, 32'h00);
    wr(8'h03, 2'd0, 32'h00);
  endtask

  task automatic t_cascade_rules();
    wr(8'h00, 2'd0, 32'h03);
    check("R7 timer0 chain err", {31'h0, err_flag}, 32'h1);
    expect_rd("R7 timer0 mode unchanged", 8'h00, 2'd0, 32'h0);
    clear_err();
    wr(8'h03, 2'd0, 32'h03);
    wr(8'h02, 2'd0, 32'h80);
    check("R7 enable before upper err", {31'h0, err_flag}, 32'h1);
    expect_rd("R7 modes after rejected enable", 8'h02, 2'd1, 32'h0003);
    clear_err();
    wr(8'h03, 2'd0, 32'h00);
  endtask

  task automatic t_mode_illegal();
    wr(8'h01, 2'd0, 32'hC0);
    check("R2 count plus load err", {31'h0, err_flag}, 32'h1);
    clear_err();
    wr(8'h01, 2'd0, 32'h84);
    check("R2 reserved bits err", {31'h0, err_flag}, 32'h1);
    clear_err();
    wr(8'h01, 2'd0, 32'h81);
    check("R2 clock select 01 err", {31'h0, err_flag}, 32'h1);
    clear_err();
    wr(8'h00, 2'd1, 32'h8080);
    check("R2 pair mode write err", {31'h0, err_flag}, 32'h1);
    expect_rd("R2 modes unchanged", 8'h00, 2'd2, 32'h0);
    clear_err();
  endtask

  task automatic t_counter_write();
    wr(8'h11, 2'd0, 32'h3C);
    wr(8'h21, 2'd0, 32'h77);
    check("R9 counter write err", {31'h0, err_flag}, 32'h1);
    expect_rd("R9 counter unchanged", 8'h21, 2'd0, 32'h3C);
    clear_err();
    expect_rd("R9 unmapped read data", 8'h40, 2'd0, 32'h0);
    check("R9 unmapped read err", {31'h0, err_flag}, 32'h1);
    clear_err();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_stopped_base();
    t_packing();
    t_bad_sizes();
    t_count();
    t_running_base();
    t_base_zero();
    t_cascade();
    t_cascade_rules();
    t_mode_illegal();
    t_counter_write();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule